// File: doc/BRIEF.md
# Scratchpad Buffer Consistency Checker

This block sits beside the scratchpad load path of a streaming multiprocessor. A tile transfer engine fills buffer slots in the scratchpad on its own. Each time it starts a slot it announces the slot's scratchpad address range, and each time it finishes one it sends a completion pulse. The checker holds those ranges and compares every scratchpad load address against the ranges that are still being filled. A warp whose load falls inside such a range is held. Loads elsewhere, and warps running code that does not touch the buffer, keep issuing. This hardware check takes the place of an explicit thread barrier after a tile copy.

Each warp keeps a mask of the slots it is waiting on. When a completion pulse clears the last slot in that mask, the warp gets a one-cycle release pulse and its held flag drops on the next cycle. A combined flag reports when every warp is held, which is the case where the scheduler has nothing to issue until a transfer ends.

Top module: `spad_guard`

## Requirements
- R1: After reset no slot is busy, no warp is held, `all_held` is 0 and no load is stalled.
- R2: A start request on `start_valid` with slot index `start_slot` records the range [`start_base`, `start_base`+`start_size`) for that slot, and the slot shows busy on `slot_busy[start_slot]` from the next cycle on. A load in the same cycle as the start request is judged against the old state.
- R3: A valid load stalls (`ld_stall`=1 in the same cycle) when its address is greater than or equal to the base of a busy range and strictly less than that range's end. An address equal to the end or one below the base is not stalled.
- R4: A load that hits no busy range, and any cycle with `ld_valid`=0, gives `ld_stall`=0. Only the warp whose load stalled becomes held (`warp_held` bit set on the next cycle); other warps are unaffected.
- R5: A completion pulse (`fin_valid` with `fin_slot`) clears that slot's busy bit on the next cycle. In the same cycle it asserts `warp_release[w]` for every held warp whose pending slots are all cleared, and those `warp_held` bits drop on the next cycle.
- R6: A warp whose load hit several busy ranges waits on all of them. Completion of an unrelated slot, or of only some of its slots, neither releases the warp nor clears its held bit.
- R7: A load in the same cycle as a slot's completion pulse is not stalled by that slot.
- R8: `all_held` is 1 exactly when every warp's `warp_held` bit is set.
- R9: A start request and a completion pulse for the same slot in the same cycle release the warps waiting on the old transfer, and the slot stays busy with the new range.
- R10: The range end is computed one bit wider than the address, so a range that ends at the top of the address space covers its last address. A range of size 0 matches no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Transfer start for a slot |
| start_slot | input | SLOT_W | Slot index being started |
| start_base | input | ADDR_W | Scratchpad base address of the buffer |
| start_size | input | ADDR_W | Buffer length in address units |
| fin_valid | input | 1 | Transfer completion pulse |
| fin_slot | input | SLOT_W | Slot index that completed |
| ld_valid | input | 1 | Scratchpad load presented this cycle |
| ld_warp | input | WARP_W | Warp issuing the load |
| ld_addr | input | ADDR_W | Scratchpad load address |
| ld_stall | output | 1 | Load hits a busy range and must be held |
| warp_held | output | NUM_WARPS | Per-warp held flags |
| warp_release | output | NUM_WARPS | Per-warp release pulse |
| slot_busy | output | NUM_SLOTS | Per-slot transfer-in-flight flags |
| all_held | output | 1 | Every warp is held |

## Verification
Two functions share a cycle here. A load can arrive in the same cycle as the completion pulse of the slot it targets, and a completion can land in the same cycle as a new start on that slot. The bench provokes the first by presenting a load inside a busy range together with that slot's completion, and expects `ld_stall`=0 and a released warp. It provokes the second by completing and restarting a slot that all warps wait on, and expects a release of every warp, then a busy slot that stalls on the new range and ignores the old one.

// File: rtl/spad_guard_pkg.sv
package spad_guard_pkg;
    localparam int DEF_SLOTS  = 4;
    localparam int DEF_WARPS  = 8;
    localparam int DEF_ADDR_W = 16;

    // Decode an index into a one-hot vector of N bits, gated by valid.
    function automatic logic [31:0] idx_onehot(input logic vld, input int unsigned idx);
        logic [31:0] v;
        v = '0;
        if (vld) v[idx] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/spad_range_slot.sv
module spad_range_slot #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_sel,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [ADDR_W-1:0] start_size,
    input  logic              fin_sel,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              busy,
    output logic              in_range
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W:0]   lim;
    } slot_st_t;

    slot_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fin_sel) begin
            st_d.busy = 1'b0;
        end
        if (start_sel) begin
            st_d.busy = 1'b1;
            st_d.base = start_base;
            st_d.lim  = {1'b0, start_base} + {1'b0, start_size};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [ADDR_W:0] addr_ext;
    assign addr_ext = {1'b0, ld_addr};
    assign busy     = st_q.busy;
    assign in_range = st_q.busy && (addr_ext >= {1'b0, st_q.base}) && (addr_ext < st_q.lim);
endmodule

// File: rtl/spad_warp_track.sv
module spad_warp_track #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] wait_set,
    input  logic [NUM_SLOTS-1:0] wait_clr,
    output logic                 held,
    output logic                 release_p
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] pend;
    } warp_st_t;

    warp_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~wait_clr) | wait_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held      = |st_q.pend;
    assign release_p = (|st_q.pend) && (st_d.pend == '0);
endmodule

// File: rtl/spad_guard.sv
module spad_guard
    import spad_guard_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int NUM_WARPS = DEF_WARPS,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    parameter int WARP_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_valid,
    input  logic [SLOT_W-1:0]    start_slot,
    input  logic [ADDR_W-1:0]    start_base,
    input  logic [ADDR_W-1:0]    start_size,
    input  logic                 fin_valid,
    input  logic [SLOT_W-1:0]    fin_slot,
    input  logic                 ld_valid,
    input  logic [WARP_W-1:0]    ld_warp,
    input  logic [ADDR_W-1:0]    ld_addr,
    output logic                 ld_stall,
    output logic [NUM_WARPS-1:0] warp_held,
    output logic [NUM_WARPS-1:0] warp_release,
    output logic [NUM_SLOTS-1:0] slot_busy,
    output logic                 all_held
);
    logic [NUM_SLOTS-1:0] start_oh;
    logic [NUM_SLOTS-1:0] fin_oh;
    logic [NUM_SLOTS-1:0] range_hit;
    logic [NUM_SLOTS-1:0] live_hit;
    logic [NUM_WARPS-1:0] ld_warp_oh;

    always_comb begin
        logic [31:0] s_oh, f_oh, w_oh;
        s_oh       = idx_onehot(start_valid, 32'(start_slot));
        f_oh       = idx_onehot(fin_valid, 32'(fin_slot));
        w_oh       = idx_onehot(ld_valid, 32'(ld_warp));
        start_oh   = s_oh[NUM_SLOTS-1:0];
        fin_oh     = f_oh[NUM_SLOTS-1:0];
        ld_warp_oh = w_oh[NUM_WARPS-1:0];
        // A slot completing this cycle no longer blocks the load.
        live_hit   = range_hit & ~fin_oh;
        ld_stall   = ld_valid && (|live_hit);
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        spad_range_slot #(
            .ADDR_W(ADDR_W)
        ) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_sel (start_oh[s]),
            .start_base(start_base),
            .start_size(start_size),
            .fin_sel   (fin_oh[s]),
            .ld_addr   (ld_addr),
            .busy      (slot_busy[s]),
            .in_range  (range_hit[s])
        );
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic [NUM_SLOTS-1:0] set_w;
        assign set_w = ld_warp_oh[w] ? live_hit : '0;
        spad_warp_track #(
            .NUM_SLOTS(NUM_SLOTS)
        ) warp_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wait_set (set_w),
            .wait_clr (fin_oh),
            .held     (warp_held[w]),
            .release_p(warp_release[w])
        );
    end

    assign all_held = &warp_held;
endmodule

// File: rtl/spad_guard_chk.sv
module spad_guard_chk #(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_WARPS = 8,
    parameter int SLOT_W    = 2,
    parameter int WARP_W    = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_valid,
    input logic [SLOT_W-1:0]    start_slot,
    input logic                 fin_valid,
    input logic [SLOT_W-1:0]    fin_slot,
    input logic                 ld_valid,
    input logic [WARP_W-1:0]    ld_warp,
    input logic                 ld_stall,
    input logic [NUM_WARPS-1:0] warp_held,
    input logic [NUM_WARPS-1:0] warp_release,
    input logic [NUM_SLOTS-1:0] slot_busy
);
    // R4: no stall without a valid load
    assert_stall_needs_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_stall |-> ld_valid);

    // R4: no stall while no slot is busy
    assert_stall_needs_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_busy == '0) |-> !ld_stall);

    // R5: a release pulse only for a held warp
    assert_release_only_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warp_release & ~warp_held) == '0);

    // R6: no release without a completion pulse
    assert_release_needs_fin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fin_valid |-> (warp_release == '0));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_s
        // R2: a started slot is busy next cycle
        assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (start_valid && start_slot == SLOT_W'(s)) |=> slot_busy[s]);
        // R5: a completed slot (not restarted) is idle next cycle
        assert_fin_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (fin_valid && fin_slot == SLOT_W'(s) && !(start_valid && start_slot == SLOT_W'(s)))
            |=> !slot_busy[s]);
    end

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        // R4: a stalled warp is held next cycle
        assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ld_stall && ld_warp == WARP_W'(w)) |=> warp_held[w]);
        // R5: a released warp is free next cycle
        assert_release_frees_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (warp_release[w] && !(ld_valid && ld_warp == WARP_W'(w))) |=> !warp_held[w]);
    end
endmodule

bind spad_guard spad_guard_chk #(
    .NUM_SLOTS(NUM_SLOTS),
    .NUM_WARPS(NUM_WARPS),
    .SLOT_W   (SLOT_W),
    .WARP_W   (WARP_W)
) chk_i (.*);

// File: tb/spad_guard_tb_top.sv
`timescale 1ns/100ps
module spad_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_valid;
    logic [1:0]  start_slot;
    logic [15:0] start_base;
    logic [15:0] start_size;
    logic        fin_valid;
    logic [1:0]  fin_slot;
    logic        ld_valid;
    logic [2:0]  ld_warp;
    logic [15:0] ld_addr;
    logic        ld_stall;
    logic [7:0]  warp_held;
    logic [7:0]  warp_release;
    logic [3:0]  slot_busy;
    logic        all_held;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    spad_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_slot(start_slot),
        .start_base(start_base), .start_size(start_size),
        .fin_valid(fin_valid), .fin_slot(fin_slot),
        .ld_valid(ld_valid), .ld_warp(ld_warp), .ld_addr(ld_addr),
        .ld_stall(ld_stall), .warp_held(warp_held), .warp_release(warp_release),
        .slot_busy(slot_busy), .all_held(all_held)
    );

    typedef struct packed {
        logic        sv;
        logic [1:0]  ss;
        logic [15:0] sb;
        logic [15:0] sz;
        logic        fv;
        logic [1:0]  fs;
        logic        lv;
        logic [2:0]  lw;
        logic [15:0] la;
        logic        es;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 2'd0, 16'h0100, 16'h0040, 1'b0, 2'd0, 1'b1, 3'd0, 16'h0110, 1'b0}, // R2 same-cycle load
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd1, 16'h0100, 1'b1}, // R3 base
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd2, 16'h013F, 1'b1}, // R3 last
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd3, 16'h0140, 1'b0}, // R3 end
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd3, 16'h00FF, 1'b0}, // R3 below
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b0, 3'd4, 16'h0120, 1'b0}, // R4 no load
        '{1'b1, 2'd2, 16'h0200, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd4, 16'h0200, 1'b0}, // R10 zero size start
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd4, 16'h0200, 1'b0}, // R10 zero size
        '{1'b1, 2'd1, 16'hFFC0, 16'h0040, 1'b0, 2'd0, 1'b1, 3'd5, 16'hFFFF, 1'b0}, // R2 not yet busy
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd5, 16'hFFFF, 1'b1}, // R10 top address
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b1, 2'd1, 1'b1, 3'd6, 16'hFFF0, 1'b0}, // R7 same-cycle fin
        '{1'b0, 2'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 3'd6, 16'hFFF0, 1'b0}  // R4 slot free
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        start_valid = 1'b0; start_slot = '0; start_base = '0; start_size = '0;
        fin_valid = 1'b0; fin_slot = '0;
        ld_valid = 1'b0; ld_warp = '0; ld_addr = '0;
    endtask

    // Inputs change at the falling edge; the rising edge follows 2.5 ns later.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic start(input logic [1:0] s, input logic [15:0] b, input logic [15:0] z);
        start_valid = 1'b1; start_slot = s; start_base = b; start_size = z;
    endtask

    task automatic load(input logic [2:0] w, input logic [15:0] a);
        ld_valid = 1'b1; ld_warp = w; ld_addr = a;
    endtask

    initial begin
        rst_n = 1'b0;
        idle();
        do_reset();
        #1;
        // R1 reset state
        chk("R1 slot_busy", 32'(slot_busy), 32'h0);
        chk("R1 warp_held", 32'(warp_held), 32'h0);
        chk("R1 all_held", 32'(all_held), 32'h0);
        load(3'd0, 16'h0000);
        #0.5;
        chk("R1 ld_stall", 32'(ld_stall), 32'h0);
        tick();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            start_valid = TBL[i].sv; start_slot = TBL[i].ss;
            start_base = TBL[i].sb; start_size = TBL[i].sz;
            fin_valid = TBL[i].fv; fin_slot = TBL[i].fs;
            ld_valid = TBL[i].lv; ld_warp = TBL[i].lw; ld_addr = TBL[i].la;
            #1;
            chk($sformatf("R2/R3/R4/R7/R10 vec%0d ld_stall", i), 32'(ld_stall), 32'(TBL[i].es));
            if (i == 10) chk("R7 release of warp5", 32'(warp_release), 32'h20);
            tick();
        end
        #1;
        // R4 only stalled warps held (1 and 2); R2 slots 0,2 busy, slot1 done
        chk("R4 warp_held mask", 32'(warp_held), 32'h06);
        chk("R2 slot_busy", 32'(slot_busy), 32'h5);

        // R5 completion releases waiters
        fin_valid = 1'b1; fin_slot = 2'd0;
        #1;
        chk("R5 warp_release", 32'(warp_release), 32'h06);
        tick();
        #1;
        chk("R5 warp_held cleared", 32'(warp_held), 32'h00);
        chk("R5 slot0 idle", 32'(slot_busy), 32'h4);

        // R6 overlapping ranges
        do_reset();
        start(2'd0, 16'h0000, 16'h0100);
        tick();
        start(2'd1, 16'h0080, 16'h0100);
        tick();
        load(3'd3, 16'h00C0);
        #1;
        chk("R6 overlap stall", 32'(ld_stall), 32'h1);
        tick();
        fin_valid = 1'b1; fin_slot = 2'd2;
        #1;
        chk("R6 unrelated fin no release", 32'(warp_release), 32'h0);
        tick();
        fin_valid = 1'b1; fin_slot = 2'd1;
        #1;
        chk("R6 partial fin no release", 32'(warp_release), 32'h0);
        tick();
        #1;
        chk("R6 still held", 32'(warp_held), 32'h08);
        fin_valid = 1'b1; fin_slot = 2'd0;
        #1;
        chk("R6 last fin release", 32'(warp_release), 32'h08);
        tick();

        // R8 all warps held
        do_reset();
        start(2'd3, 16'h0400, 16'h0010);
        tick();
        for (int w = 0; w < 8; w++) begin
            load(3'(w), 16'h0400);
            #1;
            chk($sformatf("R8 stall warp%0d", w), 32'(ld_stall), 32'h1);
            tick();
            #1;
            chk($sformatf("R8 all_held after warp%0d", w), 32'(all_held), (w == 7) ? 32'h1 : 32'h0);
        end

        // R9 completion and restart of the same slot
        fin_valid = 1'b1; fin_slot = 2'd3;
        start(2'd3, 16'h0500, 16'h0010);
        #1;
        chk("R9 release all", 32'(warp_release), 32'hFF);
        tick();
        #1;
        chk("R9 slot3 busy", 32'(slot_busy), 32'h8);
        chk("R9 all_held dropped", 32'(all_held), 32'h0);
        load(3'd0, 16'h0400);
        #1;
        chk("R9 old range free", 32'(ld_stall), 32'h0);
        tick();
        load(3'd1, 16'h0508);
        #1;
        chk("R9 new range stalls", 32'(ld_stall), 32'h1);
        tick();

        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule